// File: doc/BRIEF.md
# Timer Interrupt Router

This block takes expiry strobes from a set of timer channels and turns each into a one-clock interrupt pulse on one line of an output vector. Each channel's configuration word holds a 5-bit field that picks the line it fires. The same word holds a per-channel enable bit.

A small global configuration input carries a master enable and a legacy-replacement bit. While legacy replacement is on, the first two channels ignore their programmed fields and drive two fixed lines. Every other channel keeps its programmed route. The router also keeps a registered flag, `pit_off`, that tells an older interval timer to stand down while legacy replacement is active.

Delivery is edge-style only. Several channels that fire in the same cycle are merged onto the output vector with a bitwise OR.

Top module: `irq_router`

## Requirements
- R1: With the legacy bit (global config bit 1) set, channel 0 fires on line 0 whatever its route field (channel config bits 13:9) holds.
- R2: With the legacy bit set, channel 1 fires on line 8 whatever its route field holds.
- R3: With the legacy bit set, channels 2 and above fire on the line named by their own route field, bits 13:9.
- R4: With the legacy bit clear, every channel fires on the line named by its route field, bits 13:9.
- R5: A channel produces a pulse only when its own enable (channel config bit 2) and the global enable (global config bit 0) are both 1; otherwise its strobe has no effect on `irq_out`.
- R6: A strobe sampled at a rising edge yields a pulse on `irq_out` during the following cycle only. A single-cycle strobe leaves `irq_out` at zero one cycle later.
- R7: Channels firing in the same cycle are OR-combined, so two channels that target the same line raise that line only once, and different targets raise both lines.
- R8: `pit_off` equals the legacy bit as sampled at the previous rising edge. 1 means the interval timer should be off.
- R9: After synchronous reset, `irq_out` and `pit_off` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gcfg | input | 2 | Global config: bit 0 master enable, bit 1 legacy replacement |
| ch_cfg | input | NUM_CH*32 | Per-channel config words, channel c in bits 32c+31:32c |
| expire | input | NUM_CH | Per-channel expiry strobes |
| irq_out | output | 32 | Registered interrupt pulses, one bit per line |
| pit_off | output | 1 | Registered legacy-timer disable request |

## Verification
The bench aims at the legacy override. In that case channels 0 and 1 are given route fields that point elsewhere. A design that ignored the override would pulse the programmed lines instead of 0 and 8. A design that applied the override to channel 2 would move it as well.

Strobes are also sent with only one of the two enables set. A design that tested a single enable would leak pulses there.

Collisions on a shared line, and strobes held for one cycle, reveal a router that overwrites rather than ORs, or one that stretches its pulse. Toggling the legacy bit shows whether `pit_off` follows it with exactly one cycle of delay.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int CFG_W      = 32;
  localparam int CH_EN_BIT  = 2;
  localparam int ROUTE_LSB  = 9;
  localparam int ROUTE_W    = 5;
  localparam int N_LINES    = 1 << ROUTE_W;
  localparam int G_EN_BIT   = 0;
  localparam int G_LEG_BIT  = 1;
  localparam int LEG_LINE0  = 0;
  localparam int LEG_LINE1  = 8;

  typedef logic [ROUTE_W-1:0] route_t;
endpackage

// File: rtl/irq_chan_route.sv
module irq_chan_route
  import irq_router_pkg::*;
#(
  parameter bit USE_LEG  = 1'b0,
  parameter int LEG_LINE = 0
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic             glb_en,
  input  logic             legacy,
  input  logic             strobe,
  output logic             fire,
  output route_t           line
);
  localparam route_t FIXED = route_t'(LEG_LINE);

  route_t prog;
  assign prog = cfg[ROUTE_LSB +: ROUTE_W];
  assign fire = strobe & glb_en & cfg[CH_EN_BIT];

  generate
    if (USE_LEG) begin : g_leg
      assign line = legacy ? FIXED : prog;
    end else begin : g_prog
      assign line = prog;
    end
  endgenerate
endmodule

// File: rtl/irq_line_decode.sv
module irq_line_decode
  import irq_router_pkg::*;
(
  input  logic               en,
  input  route_t             idx,
  output logic [N_LINES-1:0] hot
);
  always_comb begin
    hot = '0;
    if (en) hot[idx] = 1'b1;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              gcfg,
  input  logic [NUM_CH*CFG_W-1:0] ch_cfg,
  input  logic [NUM_CH-1:0]       expire,
  output logic [N_LINES-1:0]      irq_out,
  output logic                    pit_off
);
  logic [N_LINES-1:0] hot [NUM_CH];
  logic [N_LINES-1:0] merged;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic   f;
      route_t l;
      irq_chan_route #(
        .USE_LEG  (c < 2),
        .LEG_LINE ((c == 0) ? LEG_LINE0 : LEG_LINE1)
      ) u_route (
        .cfg    (ch_cfg[c*CFG_W +: CFG_W]),
        .glb_en (gcfg[G_EN_BIT]),
        .legacy (gcfg[G_LEG_BIT]),
        .strobe (expire[c]),
        .fire   (f),
        .line   (l)
      );
      irq_line_decode u_dec (
        .en  (f),
        .idx (l),
        .hot (hot[c])
      );
    end
  endgenerate

  always_comb begin
    merged = '0;
    for (int i = 0; i < NUM_CH; i++) merged = merged | hot[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= '0;
      pit_off <= 1'b0;
    end else begin
      irq_out <= merged;
      pit_off <= gcfg[G_LEG_BIT];
    end
  end
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker
  import irq_router_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic [1:0]              gcfg,
  input logic [NUM_CH*CFG_W-1:0] ch_cfg,
  input logic [NUM_CH-1:0]       expire,
  input logic [N_LINES-1:0]      irq_out,
  input logic                    pit_off
);
  logic [NUM_CH-1:0] armed;
  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      armed[i] = expire[i] & ch_cfg[i*CFG_W + CH_EN_BIT];
  end

  // R5: master enable low -> no pulse next cycle
  p_master_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !gcfg[G_EN_BIT] |=> irq_out == '0);

  // R6: no armed strobe -> quiet output next cycle
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    armed == '0 |=> irq_out == '0);

  p_leg_ch0_r1: assert property (@(posedge clk) disable iff (rst)
    (gcfg == 2'b11 && armed[0]) |=> irq_out[LEG_LINE0]);

  p_leg_ch1_r2: assert property (@(posedge clk) disable iff (rst)
    (gcfg == 2'b11 && armed[1]) |=> irq_out[LEG_LINE1]);

  p_pit_follow_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pit_off == $past(gcfg[G_LEG_BIT]));

  // R7: never more lines than channels
  p_line_count_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_out) <= NUM_CH);
endmodule

bind irq_router irq_router_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .gcfg(gcfg), .ch_cfg(ch_cfg),
  .expire(expire), .irq_out(irq_out), .pit_off(pit_off)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        gcfg = '0;
  logic [NCH*W-1:0]  ch_cfg = '0;
  logic [NCH-1:0]    expire = '0;
  logic [31:0]       irq_out;
  logic              pit_off;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router #(.NUM_CH(NCH)) u_irq_router (
    .clk(clk), .rst(rst), .gcfg(gcfg), .ch_cfg(ch_cfg),
    .expire(expire), .irq_out(irq_out), .pit_off(pit_off)
  );

  function automatic logic [31:0] cfg_word(bit en, int route);
    logic [31:0] w = '0;
    w[2] = en;
    w[13:9] = route[4:0];
    return w;
  endfunction

  function automatic logic [31:0] model(logic [1:0] g, logic [NCH*W-1:0] cf,
                                        logic [NCH-1:0] ex);
    logic [31:0] v = '0;
    for (int i = 0; i < NCH; i++) begin
      logic [31:0] w = cf[i*W +: W];
      if (ex[i] && w[2] && g[0]) begin
        if (g[1] && i == 0)      v[0] = 1'b1;
        else if (g[1] && i == 1) v[8] = 1'b1;
        else                     v[w[13:9]] = 1'b1;
      end
    end
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // apply at negedge, check after the next rising edge, then drop strobes
  task automatic step(string tag, logic [1:0] g, logic [NCH*W-1:0] cf,
                      logic [NCH-1:0] ex);
    logic [31:0] e;
    @(negedge clk);
    gcfg = g; ch_cfg = cf; expire = ex;
    e = model(g, cf, ex);
    @(negedge clk);
    check(tag, irq_out, e);
    check({tag, " pit R8"}, {31'b0, pit_off}, {31'b0, g[1]});
    expire = '0;
    @(negedge clk);
    check({tag, " one-cycle R6"}, irq_out, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NCH*W-1:0] cf;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("reset R9 irq", irq_out, 32'h0);
    check("reset R9 pit", {31'b0, pit_off}, 32'h0);
    rst = 1'b0;

    cf = {cfg_word(1, 20), cfg_word(1, 17), cfg_word(1, 5)};
    step("R1 legacy ch0", 2'b11, cf, 3'b001);
    if (irq_out !== 0) ; // spacer
    step("R2 legacy ch1", 2'b11, cf, 3'b010);
    step("R3 legacy ch2 routed", 2'b11, cf, 3'b100);
    step("R4 no legacy ch0", 2'b01, cf, 3'b001);
    step("R4 no legacy ch1", 2'b01, cf, 3'b010);
    step("R5 master off", 2'b10, cf, 3'b111);
    step("R5 chan off",
         2'b01, {cfg_word(1, 20), cfg_word(0, 17), cfg_word(0, 5)}, 3'b011);
    step("R7 shared line",
         2'b01, {cfg_word(1, 9), cfg_word(1, 9), cfg_word(1, 30)}, 3'b111);
    step("R7 legacy collide line 8",
         2'b11, {cfg_word(1, 8), cfg_word(1, 3), cfg_word(1, 31)}, 3'b111);

    for (int k = 0; k < 300; k++) begin
      for (int i = 0; i < NCH; i++)
        cf[i*W +: W] = $urandom;
      step("R4 random", 2'($urandom), cf, 3'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule